// File: doc/BRIEF.md
# Wavefront Issue Arbiter with Active-Set Limit

This block picks, every cycle, at most one wavefront of a multithreaded GPU-style core to issue its next instruction. Its ready inputs are already qualified by the scoreboard and decode logic upstream. Only wavefronts in a bounded active set take part in arbitration. When a kernel is launched, a cap is loaded that bounds the size of this set, and the cap stays fixed until the next launch. Limiting the set trades latency hiding for less cache interference between wavefronts.

At launch, the lowest-indexed live wavefronts fill the active set, up to the cap. When an active wavefront reports completion, it leaves the set. On the same clock edge, the lowest-indexed live wavefront that has not yet been admitted since the launch takes its place. Within the set, selection is round-robin, starting after the wavefront granted last. With the cap at its maximum, the block acts as a plain round-robin throughput scheduler over all ready live wavefronts.

Top module: `wf_issue_arbiter`

## Requirements
- R1: After reset the active set is empty. `grant_o` is zero and `grant_vld_o` is low on every cycle until a launch admits wavefronts, even with all ready bits set.
- R2: On a cycle with `launch_i` high, the active set becomes the lowest-indexed set bits of `live_i`, up to the effective cap. A cap of 0 means NUM_WF. A wavefront outside the active set is never granted.
- R3: The grant is registered. The grant seen after clock edge k comes from `ready_i` and the active set as they stood before edge k. `grant_o` is one-hot or all-zero.
- R4: `grant_vld_o` is high exactly in the cycle after one where some active wavefront had its ready bit set.
- R5: Among eligible wavefronts, the grant goes to the first one found searching upward, with wrap, from the index after the last granted wavefront. After reset, the search starts at index 0. A launch does not move this starting point.
- R6: In a cycle with no grant, the round-robin starting point does not move.
- R7: A `done_i` bit for an active wavefront removes it from the set at the next edge. On the same edge, the lowest-indexed live, not-yet-admitted wavefronts join while room is left under the cap. A `done_i` bit on a launch cycle is ignored.
- R8: With a cap of 1, only one wavefront is ever granted until it completes.
- R9: A cap larger than the number of live wavefronts admits all of them. A wavefront that becomes live later is admitted as soon as there is room.
- R10: The active set never holds more wavefronts than the current cap.
- R11: `grant_idx_o` holds the binary index of the set bit of `grant_o`, and is zero when there is no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Kernel launch pulse; loads the cap and rebuilds the active set |
| cap_i | input | $clog2(NUM_WF+1) | Active-set cap; 0 or more than NUM_WF means NUM_WF |
| live_i | input | NUM_WF | Wavefront holds a live context |
| ready_i | input | NUM_WF | Next instruction of the wavefront can issue |
| done_i | input | NUM_WF | Completion pulse per wavefront |
| grant_o | output | NUM_WF | One-hot issue grant |
| grant_idx_o | output | $clog2(NUM_WF) | Index of the granted wavefront |
| grant_vld_o | output | 1 | A grant is present |

## Verification
A corrupted active set shows up at the grant ports one cycle later, as soon as an affected wavefront is ready. Either a ready non-member gets a grant, or a member is skipped. A wrong round-robin pointer shows as a break in the expected grant order on the first cycle with two or more eligible wavefronts. A faulty refill, in turn, shows up only once the replacement wavefront is ready: either that wavefront stays silent, or a wavefront that has already completed comes back. The bench drives all ready bits high for long stretches so that each of these errors reaches the ports within a few cycles.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  localparam int unsigned MAX_WF = 32;
endpackage

// File: rtl/wfa_rr_pick.sv
module wfa_rr_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  int pos;

  // search upward from last_i+1, wrapping
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    pos   = 0;
    for (int k = 1; k <= int'(N); k++) begin
      pos = (int'(last_i) + k) % int'(N);
      if (!any_o && req_i[pos]) begin
        any_o      = 1'b1;
        gnt_o[pos] = 1'b1;
        idx_o      = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/wfa_admit.sv
module wfa_admit #(
  parameter int unsigned N  = 32,
  parameter int unsigned CW = 6
) (
  input  logic          launch_i,
  input  logic [CW-1:0] cap_eff_i,
  input  logic [CW-1:0] cap_q_i,
  input  logic [N-1:0]  live_i,
  input  logic [N-1:0]  active_i,
  input  logic [N-1:0]  admitted_i,
  input  logic [N-1:0]  done_i,
  output logic [N-1:0]  active_o,
  output logic [N-1:0]  admitted_o
);
  logic [CW-1:0] cap_use;
  int            cnt;

  always_comb begin
    cap_use    = launch_i ? cap_eff_i : cap_q_i;
    active_o   = launch_i ? '0 : (active_i & ~done_i);
    admitted_o = launch_i ? '0 : admitted_i;
    cnt = 0;
    for (int i = 0; i < int'(N); i++) cnt += int'(active_o[i]);
    // lowest-indexed fresh live wavefronts fill free slots
    for (int i = 0; i < int'(N); i++) begin
      if (live_i[i] && !admitted_o[i] && !active_o[i] && cnt < int'(cap_use)) begin
        active_o[i]   = 1'b1;
        admitted_o[i] = 1'b1;
        cnt++;
      end
    end
  end
endmodule

// File: rtl/wf_issue_arbiter.sv
module wf_issue_arbiter
  import wfa_pkg::*;
#(
  parameter int unsigned NUM_WF = MAX_WF,
  localparam int unsigned IW = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
  localparam int unsigned CW = $clog2(NUM_WF + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CW-1:0]     cap_i,
  input  logic [NUM_WF-1:0] live_i,
  input  logic [NUM_WF-1:0] ready_i,
  input  logic [NUM_WF-1:0] done_i,
  output logic [NUM_WF-1:0] grant_o,
  output logic [IW-1:0]     grant_idx_o,
  output logic              grant_vld_o
);
  localparam logic [CW-1:0] CAP_MAX = CW'(NUM_WF);

  logic [NUM_WF-1:0] active_q, active_d, admitted_q, admitted_d;
  logic [NUM_WF-1:0] pick_gnt, grant_q;
  logic [CW-1:0]     cap_q, cap_eff;
  logic [IW-1:0]     ptr_q, pick_idx, idx_q;
  logic              pick_any, vld_q;

  assign cap_eff = (cap_i == '0 || cap_i > CAP_MAX) ? CAP_MAX : cap_i;

  wfa_admit #(.N(NUM_WF), .CW(CW)) u_admit (
    .launch_i   (launch_i),
    .cap_eff_i  (cap_eff),
    .cap_q_i    (cap_q),
    .live_i     (live_i),
    .active_i   (active_q),
    .admitted_i (admitted_q),
    .done_i     (done_i),
    .active_o   (active_d),
    .admitted_o (admitted_d)
  );

  wfa_rr_pick #(.N(NUM_WF), .IW(IW)) u_pick (
    .req_i  (active_q & ready_i),
    .last_i (ptr_q),
    .gnt_o  (pick_gnt),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= '0;
      admitted_q <= '0;
      cap_q      <= '0;
      ptr_q      <= IW'(NUM_WF - 1);
      grant_q    <= '0;
      idx_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      active_q   <= active_d;
      admitted_q <= admitted_d;
      if (launch_i) cap_q <= cap_eff;
      grant_q    <= pick_gnt;
      idx_q      <= pick_idx;
      vld_q      <= pick_any;
      if (pick_any) ptr_q <= pick_idx;
    end
  end

  assign grant_o     = grant_q;
  assign grant_idx_o = idx_q;
  assign grant_vld_o = vld_q;

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_vld_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(active_q & ready_i)) |=> grant_vld_o);
  p_vld_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(active_q & ready_i)) |=> !grant_vld_o);
  p_member_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> ((grant_o & ~$past(active_q)) == '0));
  p_ptr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(active_q & ready_i)) |=> $stable(ptr_q));
  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && |(done_i & active_q)) |=> ((active_q & $past(done_i & active_q)) == '0));
  p_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(active_q) <= int'(cap_q));
  p_idx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> grant_o[grant_idx_o]);
endmodule

// File: tb/wf_issue_arbiter_bench.sv
`timescale 1ns/1ps
module wf_issue_arbiter_bench;
  localparam int N  = 32;
  localparam int IW = 5;
  localparam int CW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          launch_i = 1'b0;
  logic [CW-1:0] cap_i = '0;
  logic [N-1:0]  live_i = '0, ready_i = '0, done_i = '0;
  logic [N-1:0]  grant_o;
  logic [IW-1:0] grant_idx_o;
  logic          grant_vld_o;

  always #2.5 clk_i = ~clk_i;

  wf_issue_arbiter u_wf_issue_arbiter (.*);

  typedef struct {
    bit           chk;
    logic [N-1:0] g;
    logic [IW-1:0] idx;
    logic         v;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // model state written from the requirements
  logic [N-1:0] m_active = '0, m_adm = '0;
  int m_cap = 0, m_ptr = N - 1;

  task automatic step(input logic ln, input int cap, input logic [N-1:0] live,
                      input logic [N-1:0] rdy, input logic [N-1:0] dn,
                      input string tag, input bit chk = 1);
    exp_t e;
    logic [N-1:0] elig, base, adm;
    int cnt, capu, pos;
    @(negedge clk_i);
    launch_i = ln; cap_i = CW'(cap); live_i = live; ready_i = rdy; done_i = dn;
    elig = m_active & rdy;
    e.chk = chk; e.g = '0; e.idx = '0; e.v = 1'b0; e.tag = tag;
    for (int k = 1; k <= N; k++) begin
      pos = (m_ptr + k) % N;
      if (!e.v && elig[pos]) begin
        e.v = 1'b1; e.g[pos] = 1'b1; e.idx = IW'(pos);
      end
    end
    q.push_back(e);
    if (e.v) m_ptr = int'(e.idx);
    if (ln) m_cap = (cap == 0 || cap > N) ? N : cap;
    capu = m_cap;
    base = ln ? '0 : (m_active & ~dn);
    adm  = ln ? '0 : m_adm;
    cnt = $countones(base);
    for (int i = 0; i < N; i++)
      if (live[i] && !adm[i] && !base[i] && cnt < capu) begin
        base[i] = 1'b1; adm[i] = 1'b1; cnt++;
      end
    m_active = base; m_adm = adm;
  endtask

  // monitor: pops one item per clock
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          checks++;
          if (grant_o !== e.g || grant_idx_o !== e.idx || grant_vld_o !== e.v) begin
            errors++;
            $display("FAIL %s: got g=%h idx=%0d v=%b exp g=%h idx=%0d v=%b",
                     e.tag, grant_o, grant_idx_o, grant_vld_o, e.g, e.idx, e.v);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    logic [N-1:0] rl, rr, rd;
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (grant_o !== '0 || grant_vld_o !== 1'b0 || grant_idx_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: got g=%h v=%b idx=%0d exp 0 0 0", grant_o, grant_vld_o, grant_idx_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    repeat (3) step(0, 0, ALL, ALL, '0, "R1 no grant before launch");
    step(1, 4, ALL, ALL, '0, "R2 launch cycle cap 4");
    repeat (8) step(0, 0, ALL, ALL, '0, "R5 round robin cap 4");
    repeat (3) step(0, 0, ALL, N'(1) << 5, '0, "R2 ready outside set");
    repeat (2) step(0, 0, ALL, '0, '0, "R6 idle hold");
    repeat (3) step(0, 0, ALL, ALL, '0, "R6 resume after last");
    step(0, 0, ALL, '0, N'(1) << 1, "R7 done pulse");
    repeat (3) step(0, 0, ALL, (N'(1) << 4) | (N'(1) << 1), '0, "R7 refill lowest fresh");
    repeat (4) step(0, 0, ALL, ALL, '0, "R7 new member rotates");
    step(1, 1, ALL, ALL, '0, "R8 launch cap 1");
    repeat (4) step(0, 0, ALL, ALL, '0, "R8 single wavefront");
    step(0, 0, ALL, ALL, N'(1), "R8 done hands over");
    repeat (3) step(0, 0, ALL, ALL, '0, "R8 next wavefront");
    step(1, 0, ALL, ALL, '0, "R2 launch cap 0");
    repeat (34) step(0, 0, ALL, ALL, '0, "R5 full round robin");
    step(1, 10, N'(32'h0000_00F0), ALL, '0, "R9 launch cap above live");
    repeat (6) step(0, 0, N'(32'h0000_00F0), ALL, '0, "R9 all live admitted");
    repeat (6) step(0, 0, N'(32'h0010_00F0), ALL, '0, "R9 late live joins");
    step(1, 40, ALL, ALL, '0, "R9 cap over max");
    repeat (34) step(0, 0, ALL, ALL, '0, "R9 cap over max rr");
    step(1, 3, ALL, ALL, ALL, "R7 done on launch ignored");
    repeat (4) step(0, 0, ALL, ALL, '0, "R7 launch set intact");

    for (int n = 0; n < 3000; n++) begin
      bit ln;
      int cp;
      rr = {$urandom, $urandom} [N-1:0];
      rd = ($urandom_range(0, 3) == 0) ? (m_active & N'($urandom)) : '0;
      rl = ($urandom_range(0, 7) == 0) ? N'($urandom) | N'($urandom) : ALL;
      ln = ($urandom_range(0, 99) == 0);
      cp = $urandom_range(0, 40);
      step(ln, cp, rl, rr, rd, "R3 R4 R10 R11 random");
    end

    step(0, 0, ALL, '0, '0, "drain", 0);
    wait (q.size() == 0);
    @(negedge clk_i);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule